// File: doc/BRIEF.md
# Stopwatch and Interval Timer

This peripheral contains two counters that advance together on a slow tick. A prescaler divides the system clock by a fixed constant to make that tick. The first counter is a free-running stopwatch that wraps. The second is an interval timer that reloads itself. Its period is set by a programmed value. Each time the timer runs out, it sets a sticky interrupt-pending flag. The interrupt controller clears the flag through an acknowledge input.

Software uses a small word-wide register port. Address 0 holds the stopwatch. Address 1 holds the timer's programmed value. Reads come back combinationally, zero-extended to the bus width. Any write to the stopwatch clears it, whatever the data. A write to the timer that covers only one byte lane has that byte copied into every lane before it is stored. Writing the timer also restarts its count. The prescaler keeps running through every write.

Top module: `swt_top`

## Requirements
- R1: One tick occurs every PRESC clock cycles, counted from reset release. The stopwatch, read at address 0 in bits [SW_W-1:0], rises by exactly one per tick.
- R2: The stopwatch wraps from 2^SW_W-1 to 0.
- R3: A write to address 0 with any nonzero byte enable sets the stopwatch to 0, whatever the data. If a tick falls on the same cycle as the write, the write wins. Counting then resumes on the next tick.
- R4: A write to address 1 stores the programmed value, read back at address 1 in bits [TMR_W-1:0], and restarts the timer. The first tick after the write only loads the programmed value and causes no expiry.
- R5: For a programmed value N > 0, the first expiry happens on the (N+2)-th tick after the write. Later expiries follow every N+1 ticks, reloading from the programmed value each time.
- R6: A programmed value of 0 leaves the timer idle, and it never expires.
- R7: A write whose byte enable selects exactly one byte lane copies that byte into all lanes before the store. For example, byte enable 2'b10 with data 16'h07AA stores 8'h07.
- R8: An expiry sets irq_pending one clock after the expiring tick. The flag then stays high until it is acknowledged. An expiry on the same cycle as irq_ack leaves the flag set.
- R9: irq_ack high on a clock edge with no expiry clears irq_pending.
- R10: After reset the stopwatch, the programmed value and irq_pending are all zero.
- R11: A write with byte enable 2'b00 changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 stopwatch, 1 timer value |
| bus_be | input | DATA_W/8 | Byte-lane enables for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| irq_ack | input | 1 | Acknowledge of the timer interrupt |
| irq_pending | output | 1 | Sticky timer interrupt pending flag |

## Verification
Each timer period is swept over a range of values, and every cycle is compared with expiry edges worked out arithmetically from the write cycle. This catches two common faults. A timer that counts N or N+2 ticks per period would show the wrong spacing. A timer that expires on the loading tick would show a first interval that is too short. The stopwatch is run past its wrap point, and one clear is timed to land on a tick edge. A design that let the tick win would read 1 instead of 0 after that clear. A design that saturated would stay stuck at all-ones. Single-lane writes carry a different byte in the unused lane, so a design without lane copying stores the wrong value. Holding irq_ack high across an expiry shows whether the acknowledge wrongly takes priority over a new expiry.

// File: rtl/swt_pkg.sv
package swt_pkg;
   typedef enum logic {
      REG_STOPWATCH = 1'b0,
      REG_INTERVAL  = 1'b1
   } swt_reg_e;
endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler #(
   parameter int PRESC = 384
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (PRESC > 1) ? $clog2(PRESC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESC - 1);

   logic [CNT_W-1:0] cnt_q;

   if (PRESC < 2) begin : g_bad_presc
      $error("swt_prescaler: PRESC must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/swt_regif.sv
module swt_regif
   import swt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SW_W   = 12,
   parameter int TMR_W  = 8
) (
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [SW_W-1:0]   sw_val,
   input  logic [TMR_W-1:0]  tmr_val,
   output logic              sw_clr,
   output logic              tmr_wr,
   output logic [TMR_W-1:0]  tmr_wval,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0][7:0] lane_pick;
   logic [7:0]            single_byte;
   logic [DATA_W-1:0]     wide_word;
   logic                  any_lane;
   logic                  one_lane;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_dw
      $error("swt_regif: DATA_W must be a positive multiple of 8");
   end
   if (SW_W > DATA_W || TMR_W > DATA_W) begin : g_bad_fw
      $error("swt_regif: register fields must fit in DATA_W");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_pick[i] = bus_be[i] ? bus_wdata[i*8 +: 8] : 8'h00;
   end

   always_comb begin
      single_byte = 8'h00;
      for (int i = 0; i < LANES; i++) begin
         single_byte = single_byte | lane_pick[i];
      end
   end

   assign any_lane  = |bus_be;
   assign one_lane  = ($countones(bus_be) == 1);
   assign wide_word = one_lane ? {LANES{single_byte}} : bus_wdata;

   assign sw_clr   = bus_wr && any_lane && (swt_reg_e'(bus_addr) == REG_STOPWATCH);
   assign tmr_wr   = bus_wr && any_lane && (swt_reg_e'(bus_addr) == REG_INTERVAL);
   assign tmr_wval = wide_word[TMR_W-1:0];

   always_comb begin
      bus_rdata = '0;
      if (swt_reg_e'(bus_addr) == REG_STOPWATCH) begin
         bus_rdata[SW_W-1:0] = sw_val;
      end else begin
         bus_rdata[TMR_W-1:0] = tmr_val;
      end
   end
endmodule

// File: rtl/swt_stopwatch.sv
module swt_stopwatch #(
   parameter int SW_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   output logic [SW_W-1:0] count
);
   logic [SW_W-1:0] count_q;

   if (SW_W < 2) begin : g_bad_sw
      $error("swt_stopwatch: SW_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clr) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count = count_q;
endmodule

// File: rtl/swt_interval.sv
module swt_interval #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_wr,
   input  logic [TMR_W-1:0] load_val,
   input  logic             irq_ack,
   output logic [TMR_W-1:0] prog,
   output logic             expire,
   output logic             pending
);
   logic [TMR_W-1:0] prog_q;
   logic [TMR_W-1:0] cnt_q;
   logic             armed_q;
   logic             pend_q;

   if (TMR_W < 1) begin : g_bad_tw
      $error("swt_interval: TMR_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q  <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_wr) begin
         prog_q  <= load_val;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (tick) begin
         if (!armed_q) begin
            if (prog_q != '0) begin
               cnt_q   <= prog_q;
               armed_q <= 1'b1;
            end
         end else if (cnt_q == '0) begin
            cnt_q   <= prog_q;
            armed_q <= (prog_q != '0);
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign expire = tick && !load_wr && armed_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (expire) begin
         pend_q <= 1'b1;
      end else if (irq_ack) begin
         pend_q <= 1'b0;
      end
   end

   assign prog    = prog_q;
   assign pending = pend_q;
endmodule

// File: rtl/swt_top.sv
module swt_top #(
   parameter int PRESC  = 384,
   parameter int DATA_W = 16,
   parameter int SW_W   = 12,
   parameter int TMR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                irq_ack,
   output logic                irq_pending
);
   logic             tick;
   logic             sw_clr;
   logic             tmr_wr;
   logic [TMR_W-1:0] tmr_wval;
   logic [SW_W-1:0]  sw_val;
   logic [TMR_W-1:0] tmr_val;
   logic             expire;

   swt_prescaler #(.PRESC(PRESC)) presc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   swt_regif #(.DATA_W(DATA_W), .SW_W(SW_W), .TMR_W(TMR_W)) regif_i (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .sw_val    (sw_val),
      .tmr_val   (tmr_val),
      .sw_clr    (sw_clr),
      .tmr_wr    (tmr_wr),
      .tmr_wval  (tmr_wval),
      .bus_rdata (bus_rdata)
   );

   swt_stopwatch #(.SW_W(SW_W)) sw_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (sw_clr),
      .count (sw_val)
   );

   swt_interval #(.TMR_W(TMR_W)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load_wr  (tmr_wr),
      .load_val (tmr_wval),
      .irq_ack  (irq_ack),
      .prog     (tmr_val),
      .expire   (expire),
      .pending  (irq_pending)
   );
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
   parameter int SW_W  = 12,
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             sw_clr,
   input logic [SW_W-1:0]  sw_val,
   input logic [TMR_W-1:0] tmr_val,
   input logic             expire,
   input logic             irq_ack,
   input logic             irq_pending
);
   // R1: ticks are never back to back
   a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R1, R2: one step per tick, wrapping in SW_W bits
   a_r2_sw_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sw_clr) |=> (sw_val == SW_W'($past(sw_val) + 1'b1)));

   // R3: clear wins and leaves zero
   a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> (sw_val == '0));

   // R6: zero value never expires
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_val == '0) |-> !expire);

   // R8: expiry sets the flag
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq_pending);

   // R8: sticky without acknowledge
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pending && !irq_ack) |=> irq_pending);

   // R9: acknowledge clears
   a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !expire) |=> !irq_pending);
endmodule

bind swt_top swt_checker #(.SW_W(SW_W), .TMR_W(TMR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .sw_clr      (sw_clr),
   .sw_val      (sw_val),
   .tmr_val     (tmr_val),
   .expire      (expire),
   .irq_ack     (irq_ack),
   .irq_pending (irq_pending)
);

// File: tb/swt_top_tb_top.sv
module swt_top_tb_top;
   localparam int PRESC  = 4;
   localparam int DATA_W = 16;
   localparam int SW_W   = 12;
   localparam int TMR_W  = 8;
   localparam int SW_MOD = 1 << SW_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_wr;
   logic              bus_addr;
   logic [1:0]        bus_be;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq_ack;
   logic              irq_pending;

   int cyc;
   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   swt_top #(.PRESC(PRESC), .DATA_W(DATA_W), .SW_W(SW_W), .TMR_W(TMR_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_be      (bus_be),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_ack     (irq_ack),
      .irq_pending (irq_pending)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the write edge count
   task automatic wr(input bit a, input logic [1:0] be, input logic [15:0] d, output int w);
      bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 2'b00; bus_wdata = '0;
      w = cyc;
   endtask

   task automatic rd(input bit a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   function automatic int sw_expect(input int e, input int w);
      return ((e / PRESC) - (w / PRESC)) % SW_MOD;
   endfunction

   function automatic bit hit(input int e, input int base, input int n);
      int t;
      if (n == 0 || (e % PRESC) != 0) return 1'b0;
      t = e / PRESC - base;
      if (t < n + 2) return 1'b0;
      return ((t - n - 2) % (n + 1)) == 0;
   endfunction

   // R4, R5, R6, R8, R9: per-cycle comparison of irq_pending against computed expiry edges
   task automatic run_timer(input int n, input bit hold_ack, input int expiries, input string req);
      int w, base, seen, errs, lim, v, first_act, first_exp;
      bit exp_p;
      wr(1'b1, 2'b11, 16'(n), w);
      rd(1'b1, v);
      check(v == n, "R4 programmed value readback", v, n);
      base = w / PRESC;
      seen = 0; errs = 0; first_act = 0; first_exp = 0;
      lim = (n + 2 + expiries * (n + 1) + 2) * PRESC;
      if (n == 0) lim = 200;
      for (int k = 0; k < lim; k++) begin
         exp_p = hit(cyc, base, n);
         if (irq_pending !== exp_p) begin
            if (errs == 0) begin first_act = int'(irq_pending); first_exp = int'(exp_p); end
            errs++;
         end
         if (exp_p) seen++;
         if (n != 0 && seen >= expiries && !exp_p) break;
         irq_ack = hold_ack ? 1'b1 : irq_pending;
         @(negedge clk);
      end
      check(errs == 0, req, first_act, first_exp);
      if (n != 0) check(seen >= expiries, {req, " expiry count"}, seen, expiries);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int v, w, w2, errs, fa, fe;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_be = 2'b00;
      bus_wdata = '0; irq_ack = 1'b0;
      repeat (4) @(negedge clk);
      // R10: reset state
      rd(1'b0, v); check(v == 0, "R10 stopwatch at reset", v, 0);
      rd(1'b1, v); check(v == 0, "R10 timer value at reset", v, 0);
      check(irq_pending == 1'b0, "R10 pending at reset", int'(irq_pending), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: stopwatch counts ticks from reset release
      errs = 0; fa = 0; fe = 0;
      for (int k = 0; k < 64; k++) begin
         rd(1'b0, v);
         if (v != sw_expect(cyc, 0)) begin
            if (errs == 0) begin fa = v; fe = sw_expect(cyc, 0); end
            errs++;
         end
         @(negedge clk);
      end
      check(errs == 0, "R1 one step per PRESC cycles", fa, fe);

      // R3: clear with nonzero data landing on a tick edge
      while ((cyc % PRESC) != PRESC - 1) @(negedge clk);
      wr(1'b0, 2'b11, 16'hFFFF, w);
      rd(1'b0, v);
      check((w % PRESC) == 0 && v == 0, "R3 clear wins over tick", v, 0);
      repeat (PRESC) @(negedge clk);
      rd(1'b0, v);
      check(v == sw_expect(cyc, w), "R3 counting resumes", v, sw_expect(cyc, w));

      // R3: byte-lane clear mid-interval
      while ((cyc % PRESC) != 1) @(negedge clk);
      wr(1'b0, 2'b10, 16'h5A00, w);
      rd(1'b0, v); check(v == 0, "R3 upper-lane write clears", v, 0);

      // R1, R2: long run across the wrap point
      errs = 0; fa = 0; fe = 0;
      for (int k = 0; k < (SW_MOD + 40) * PRESC; k++) begin
         rd(1'b0, v);
         if (v != sw_expect(cyc, w)) begin
            if (errs == 0) begin fa = v; fe = sw_expect(cyc, w); end
            errs++;
         end
         @(negedge clk);
      end
      check(errs == 0, "R2 stopwatch wraps at 2^SW_W", fa, fe);

      // R11: zero byte enable ignored
      rd(1'b0, v);
      wr(1'b0, 2'b00, 16'h0000, w2);
      rd(1'b0, v);
      check(v == sw_expect(cyc, w), "R11 stopwatch kept", v, sw_expect(cyc, w));

      // R7: lane copying
      wr(1'b1, 2'b10, 16'h07AA, w2);
      rd(1'b1, v); check(v == 16'h0007, "R7 upper lane copied", v, 16'h0007);
      wr(1'b1, 2'b01, 16'h3305, w2);
      rd(1'b1, v); check(v == 16'h0005, "R7 lower lane copied", v, 16'h0005);
      wr(1'b1, 2'b00, 16'h00FF, w2);
      rd(1'b1, v); check(v == 16'h0005, "R11 timer value kept", v, 16'h0005);
      wr(1'b1, 2'b11, 16'h0000, w2);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

      // R5: period sweep with prompt acknowledge
      for (int n = 1; n <= 9; n++) run_timer(n, 1'b0, 3, "R5 expiry spacing");
      run_timer(255, 1'b0, 2, "R5 largest value");

      // R6: zero value stays idle
      run_timer(0, 1'b0, 0, "R6 idle timer");

      // R8: acknowledge held across expiries, expiry still sets
      run_timer(2, 1'b1, 3, "R8 expiry beats acknowledge");

      // R8, R9: sticky flag then acknowledge clear
      wr(1'b1, 2'b11, 16'h0002, w);
      repeat ((2 + 2) * PRESC + 40) @(negedge clk);
      check(irq_pending == 1'b1, "R8 pending held without ack", int'(irq_pending), 1);
      while ((cyc % PRESC) != 0) @(negedge clk);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check(irq_pending == 1'b0, "R9 acknowledge clears", int'(irq_pending), 0);
      wr(1'b1, 2'b11, 16'h0000, w);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      done = 1'b1;
      $finish;
   end
endmodule